// File: doc/BRIEF.md
# Filter Storage Loader

This block moves words from a narrow 12-bit host bus into the storage of a multi-tap filter. It holds one coefficient bank per multiplier and four register files: configuration, round, select and limit. The host pulls an active-low load strobe low and presents an address word. It then presents one or more data words, one per clock. A coefficient load streams any number of words into consecutive bank locations after a single address. A register load takes either one data word or three data words, depending on the register's width.

A pause input freezes the sequence wherever it stands. While pause is high, bus words are ignored and nothing is written. Loading resumes at the same position once pause drops. Raising the strobe ends the current sequence at any point. The write strobes, address and data for each storage class come out on ports. The stored contents can be read back through combinational read ports for the filter datapath.

Top module: `coef_loader`

## Requirements
- R1: A synchronous active-low reset clears every coefficient location and every configuration, round, select and limit register to zero, and returns the loader to waiting for an address word.
- R2: The first clock with the strobe low and pause low takes the bus word as an address word. Bits 11..8 give the class: values 0 to NUM_BANKS-1 pick that coefficient bank, 8 is configuration (index in bits 1..0), 9 is round, 10 is select and 11 is limit (index in bits 3..0 for these three).
- R3: After a coefficient address word, each unpaused data word is written to the chosen bank on the clock that captures it, at locations 0, 1, 2 and so on.
- R4: The coefficient write location wraps from DEPTH-1 back to 0 when more than DEPTH words follow one address.
- R5: A configuration or select load writes its register on the clock that captures the single data word. A configuration register keeps all 12 bits and a select register keeps bits 4..0. Further words are ignored until the strobe is released.
- R6: A round or limit load takes three data words, least significant first. The register gets {word2[7:0], word1, word0} on the clock that captures the third word.
- R7: While pause is high, bus words are ignored, nothing is written, and the sequence position and state hold.
- R8: Raising the strobe ends any sequence. A partly received three-word value is dropped, and the next low strobe starts with a new address word.
- R9: An address with an unknown class (4 to 7 with the default NUM_BANKS=4, or 12 to 15) causes every following data word to be ignored until the strobe is released.
- R10: At most one write strobe is asserted in any cycle. A strobe is asserted only in a cycle where the load strobe is low and pause is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Active-low load strobe |
| pause | input | 1 | Freeze the load sequence |
| ld_word | input | 12 | Address or data word from the host |
| coef_we | output | NUM_BANKS | Per-bank coefficient write strobe |
| coef_waddr | output | log2(DEPTH) | Coefficient write location |
| coef_wdata | output | 12 | Coefficient write data |
| cfg_we | output | 1 | Configuration register write strobe |
| rnd_we | output | 1 | Round register write strobe |
| sel_we | output | 1 | Select register write strobe |
| lim_we | output | 1 | Limit register write strobe |
| reg_widx | output | 4 | Register index being written |
| reg_wdata | output | 32 | Assembled register write data |
| rd_bank | input | log2(NUM_BANKS) | Coefficient read bank |
| rd_addr | input | log2(DEPTH) | Coefficient read location |
| rd_idx | input | 4 | Register read index |
| coef_rdata | output | 12 | Coefficient read data |
| cfg_rdata | output | 12 | Configuration register rd_idx[1:0] |
| rnd_rdata | output | 32 | Round register rd_idx |
| sel_rdata | output | 5 | Select register rd_idx |
| lim_rdata | output | 32 | Limit register rd_idx |

## Verification
The assertions assume that the load strobe and pause are synchronous to the clock and hold known values from the first edge after reset. The pointer, state-hold and write-landing properties rely on this. They also assume that the host never expects a register write after a release of the strobe it did not follow with a new address. The bench drives every input only on the falling clock edge, always with defined values. It sets the read-back selectors only while the strobe is high, so every sampled read sees settled storage.

// File: rtl/coef_loader_pkg.sv
// Package: shared constants and types for the filter storage loader.
// Assumes a 12-bit host word and a 4-bit class field at bits 11..8.
package coef_loader_pkg;

    localparam int WORD_W = 12;
    localparam int CLS_LSB = 8;

    localparam logic [3:0] CLS_CFG = 4'h8;
    localparam logic [3:0] CLS_RND = 4'h9;
    localparam logic [3:0] CLS_SEL = 4'hA;
    localparam logic [3:0] CLS_LIM = 4'hB;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COEF,
        ST_SINGLE,
        ST_TRIPLE,
        ST_DRAIN
    } ld_state_e;

    typedef enum logic [1:0] {
        TG_CFG,
        TG_RND,
        TG_SEL,
        TG_LIM
    } reg_tgt_e;

endpackage

// File: rtl/coef_loader_seq.sv
// Module: load sequencer. Decodes the address word, tracks the stream
// position, assembles three-word values and produces all write strobes.
// Assumes ld_n and pause are synchronous to clk.
module coef_loader_seq
    import coef_loader_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 256,
    parameter int NUM_REGS  = 16,
    parameter int REG_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_n,
    input  logic                         pause,
    input  logic [WORD_W-1:0]            ld_word,
    output logic [NUM_BANKS-1:0]         coef_we,
    output logic [$clog2(DEPTH)-1:0]     coef_waddr,
    output logic [WORD_W-1:0]            coef_wdata,
    output logic                         cfg_we,
    output logic                         rnd_we,
    output logic                         sel_we,
    output logic                         lim_we,
    output logic [$clog2(NUM_REGS)-1:0]  reg_widx,
    output logic [REG_W-1:0]             reg_wdata
);

    localparam int AW = $clog2(DEPTH);
    localparam int BW = $clog2(NUM_BANKS);
    localparam int IW = $clog2(NUM_REGS);
    localparam int ACC_W = 2 * WORD_W;
    localparam int TOP_W = REG_W - ACC_W;

    ld_state_e         state;
    reg_tgt_e          tgt;
    logic [BW-1:0]     bank;
    logic [AW-1:0]     ptr;
    logic [IW-1:0]     idx;
    logic [1:0]        wcnt;
    logic [ACC_W-1:0]  acc;
    logic              go;
    logic [3:0]        cls;

    assign go  = !ld_n && !pause;
    assign cls = ld_word[CLS_LSB +: 4];

    // Sequence state, decode of the address word and stream position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tgt   <= TG_CFG;
            bank  <= '0;
            ptr   <= '0;
            idx   <= '0;
            wcnt  <= '0;
            acc   <= '0;
        end else if (ld_n) begin
            state <= ST_IDLE;
            ptr   <= '0;
            wcnt  <= '0;
        end else if (!pause) begin
            case (state)
                ST_IDLE: begin
                    ptr  <= '0;
                    wcnt <= '0;
                    idx  <= ld_word[IW-1:0];
                    bank <= ld_word[CLS_LSB +: BW];
                    if (int'(cls) < NUM_BANKS) begin
                        state <= ST_COEF;
                    end else if (cls == CLS_CFG) begin
                        state <= ST_SINGLE;
                        tgt   <= TG_CFG;
                    end else if (cls == CLS_SEL) begin
                        state <= ST_SINGLE;
                        tgt   <= TG_SEL;
                    end else if (cls == CLS_RND) begin
                        state <= ST_TRIPLE;
                        tgt   <= TG_RND;
                    end else if (cls == CLS_LIM) begin
                        state <= ST_TRIPLE;
                        tgt   <= TG_LIM;
                    end else begin
                        state <= ST_DRAIN;
                    end
                end
                ST_COEF: ptr <= ptr + 1'b1;
                ST_SINGLE: state <= ST_DRAIN;
                ST_TRIPLE: begin
                    if (wcnt == 2'd2) begin
                        state <= ST_DRAIN;
                    end else begin
                        if (wcnt == 2'd0) acc[WORD_W-1:0] <= ld_word;
                        else              acc[ACC_W-1:WORD_W] <= ld_word;
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: state <= ST_DRAIN;
            endcase
        end
    end

    // Write strobes, address and data for the cycle's captured word.
    always_comb begin
        coef_we    = '0;
        coef_waddr = ptr;
        coef_wdata = ld_word;
        cfg_we     = 1'b0;
        rnd_we     = 1'b0;
        sel_we     = 1'b0;
        lim_we     = 1'b0;
        reg_widx   = idx;
        reg_wdata  = {{(REG_W-WORD_W){1'b0}}, ld_word};
        if (go) begin
            if (state == ST_COEF) coef_we[bank] = 1'b1;
            if (state == ST_SINGLE) begin
                cfg_we = (tgt == TG_CFG);
                sel_we = (tgt == TG_SEL);
            end
            if (state == ST_TRIPLE && wcnt == 2'd2) begin
                reg_wdata = {ld_word[TOP_W-1:0], acc};
                rnd_we    = (tgt == TG_RND);
                lim_we    = (tgt == TG_LIM);
            end
        end
    end

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({coef_we, cfg_we, rnd_we, sel_we, lim_we}));

    // R7
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !ld_n) |=> ($stable(ptr) && $stable(state) && $stable(wcnt)));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COEF && go) |=> (ptr == AW'($past(ptr) + 1'b1)));

    // R8
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> (state == ST_IDLE && wcnt == 2'd0));

    // R9
    drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (coef_we == '0 && !cfg_we && !rnd_we && !sel_we && !lim_we));

endmodule

// File: rtl/coef_loader_bank.sv
// Module: coefficient storage, one bank per multiplier, each DEPTH words.
// Assumes at most one bank write strobe per cycle (checked in the sequencer).
module coef_loader_bank
    import coef_loader_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS-1:0]          we,
    input  logic [$clog2(DEPTH)-1:0]      waddr,
    input  logic [WORD_W-1:0]             wdata,
    input  logic [$clog2(NUM_BANKS)-1:0]  rd_bank,
    input  logic [$clog2(DEPTH)-1:0]      rd_addr,
    output logic [WORD_W-1:0]             rdata
);

    logic [WORD_W-1:0] bank_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [WORD_W-1:0] mem [DEPTH];

        // Clear on reset, otherwise store the word when this bank is strobed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we[b]) begin
                mem[waddr] <= wdata;
            end
        end

        assign bank_q[b] = mem[rd_addr];

        // R3
        coef_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we[b] |=> (mem[$past(waddr)] == $past(wdata)));
    end

    assign rdata = bank_q[rd_bank];

endmodule

// File: rtl/coef_loader_regs.sv
// Module: configuration, round, select and limit register files.
// Assumes the sequencer raises at most one write strobe per cycle.
module coef_loader_regs
    import coef_loader_pkg::*;
#(
    parameter int CFG_REGS = 4,
    parameter int NUM_REGS = 16,
    parameter int SEL_W    = 5,
    parameter int REG_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic                         rnd_we,
    input  logic                         sel_we,
    input  logic                         lim_we,
    input  logic [$clog2(NUM_REGS)-1:0]  widx,
    input  logic [REG_W-1:0]             wdata,
    input  logic [$clog2(NUM_REGS)-1:0]  rd_idx,
    output logic [WORD_W-1:0]            cfg_rdata,
    output logic [REG_W-1:0]             rnd_rdata,
    output logic [SEL_W-1:0]             sel_rdata,
    output logic [REG_W-1:0]             lim_rdata
);

    localparam int CW = $clog2(CFG_REGS);

    logic [WORD_W-1:0] cfg_q [CFG_REGS];
    logic [REG_W-1:0]  rnd_q [NUM_REGS];
    logic [SEL_W-1:0]  sel_q [NUM_REGS];
    logic [REG_W-1:0]  lim_q [NUM_REGS];
    logic              unused_hi;

    assign unused_hi = ^{widx[$clog2(NUM_REGS)-1:CW], rd_idx[$clog2(NUM_REGS)-1:CW]};

    // Configuration file: one full host word per register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CFG_REGS; i++) cfg_q[i] <= '0;
        end else if (cfg_we) begin
            cfg_q[widx[CW-1:0]] <= wdata[WORD_W-1:0];
        end
    end

    // Round, select and limit files, written by index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                rnd_q[i] <= '0;
                sel_q[i] <= '0;
                lim_q[i] <= '0;
            end
        end else begin
            if (rnd_we) rnd_q[widx] <= wdata;
            if (sel_we) sel_q[widx] <= wdata[SEL_W-1:0];
            if (lim_we) lim_q[widx] <= wdata;
        end
    end

    assign cfg_rdata = cfg_q[rd_idx[CW-1:0]];
    assign rnd_rdata = rnd_q[rd_idx];
    assign sel_rdata = sel_q[rd_idx];
    assign lim_rdata = lim_q[rd_idx];

    // R5
    cfg_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q[$past(widx[CW-1:0])] == $past(wdata[WORD_W-1:0])));

    // R5
    sel_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> (sel_q[$past(widx)] == $past(wdata[SEL_W-1:0])));

    // R6
    rnd_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_we |=> (rnd_q[$past(widx)] == $past(wdata)));

    // R6
    lim_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_we |=> (lim_q[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/coef_loader.sv
// Module: top of the filter storage loader. Ties the sequencer to the
// coefficient banks and register files and exposes write and read ports.
// Assumes NUM_BANKS is between 2 and 8 and DEPTH is a power of two.
module coef_loader
    import coef_loader_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 256,
    parameter int CFG_REGS  = 4,
    parameter int NUM_REGS  = 16,
    parameter int SEL_W     = 5,
    parameter int REG_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_n,
    input  logic                          pause,
    input  logic [11:0]                   ld_word,
    output logic [NUM_BANKS-1:0]          coef_we,
    output logic [$clog2(DEPTH)-1:0]      coef_waddr,
    output logic [11:0]                   coef_wdata,
    output logic                          cfg_we,
    output logic                          rnd_we,
    output logic                          sel_we,
    output logic                          lim_we,
    output logic [$clog2(NUM_REGS)-1:0]   reg_widx,
    output logic [REG_W-1:0]              reg_wdata,
    input  logic [$clog2(NUM_BANKS)-1:0]  rd_bank,
    input  logic [$clog2(DEPTH)-1:0]      rd_addr,
    input  logic [$clog2(NUM_REGS)-1:0]   rd_idx,
    output logic [11:0]                   coef_rdata,
    output logic [11:0]                   cfg_rdata,
    output logic [REG_W-1:0]              rnd_rdata,
    output logic [SEL_W-1:0]              sel_rdata,
    output logic [REG_W-1:0]              lim_rdata
);

    coef_loader_seq #(
        .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .NUM_REGS(NUM_REGS), .REG_W(REG_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .pause(pause), .ld_word(ld_word),
        .coef_we(coef_we), .coef_waddr(coef_waddr), .coef_wdata(coef_wdata),
        .cfg_we(cfg_we), .rnd_we(rnd_we), .sel_we(sel_we), .lim_we(lim_we),
        .reg_widx(reg_widx), .reg_wdata(reg_wdata)
    );

    coef_loader_bank #(
        .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_waddr),
        .wdata(coef_wdata), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .rdata(coef_rdata)
    );

    coef_loader_regs #(
        .CFG_REGS(CFG_REGS), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W), .REG_W(REG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .rnd_we(rnd_we),
        .sel_we(sel_we), .lim_we(lim_we), .widx(reg_widx), .wdata(reg_wdata),
        .rd_idx(rd_idx), .cfg_rdata(cfg_rdata), .rnd_rdata(rnd_rdata),
        .sel_rdata(sel_rdata), .lim_rdata(lim_rdata)
    );

endmodule

// File: tb/coef_loader_tb.sv
module coef_loader_tb;

    localparam int STIM_N = 41;
    localparam int CHK_N  = 11;

    typedef struct packed {
        logic [15:0] tag;
        logic [2:0]  kind;
        logic [3:0]  idx;
        logic [7:0]  addr;
        logic [31:0] exp;
    } chk_t;

    // {ld_n, pause, word}
    localparam logic [13:0] STIM [STIM_N] = '{
        14'h2000, 14'h0802, 14'h0ABC, 14'h0111, 14'h2000,
        14'h0A05, 14'h003F, 14'h2000,
        14'h0907, 14'h0321, 14'h1EEE, 14'h0654, 14'h0F87, 14'h2000,
        14'h0B03, 14'h0111, 14'h2000,
        14'h0B03, 14'h0222, 14'h0333, 14'h0044, 14'h2000,
        14'h0C00, 14'h0555, 14'h0666, 14'h2000,
        14'h0100, 14'h0010, 14'h1FFF, 14'h0011, 14'h0012, 14'h2000,
        14'h0500, 14'h0777, 14'h2000,
        14'h1000, 14'h0902, 14'h0001, 14'h0002, 14'h0003, 14'h2000
    };

    // kind: 0 cfg, 1 round, 2 select, 3 limit, 4 coef (idx = bank)
    localparam chk_t CHK [CHK_N] = '{
        '{"R5", 3'd0, 4'd2, 8'd0, 32'h0000_0ABC},
        '{"R5", 3'd2, 4'd5, 8'd0, 32'h0000_001F},
        '{"R6", 3'd1, 4'd7, 8'd0, 32'h8765_4321},
        '{"R8", 3'd3, 4'd3, 8'd0, 32'h4433_3222},
        '{"R9", 3'd0, 4'd0, 8'd0, 32'h0000_0000},
        '{"R9", 3'd1, 4'd0, 8'd0, 32'h0000_0000},
        '{"R3", 3'd4, 4'd1, 8'd0, 32'h0000_0010},
        '{"R7", 3'd4, 4'd1, 8'd1, 32'h0000_0011},
        '{"R3", 3'd4, 4'd1, 8'd2, 32'h0000_0012},
        '{"R9", 3'd4, 4'd0, 8'd0, 32'h0000_0000},
        '{"R2", 3'd1, 4'd2, 8'd0, 32'h0300_2001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_n = 1'b1;
    logic        pause = 1'b0;
    logic [11:0] ld_word = '0;
    logic [3:0]  coef_we;
    logic [7:0]  coef_waddr;
    logic [11:0] coef_wdata;
    logic        cfg_we, rnd_we, sel_we, lim_we;
    logic [3:0]  reg_widx;
    logic [31:0] reg_wdata;
    logic [1:0]  rd_bank = '0;
    logic [7:0]  rd_addr = '0;
    logic [3:0]  rd_idx = '0;
    logic [11:0] coef_rdata, cfg_rdata;
    logic [31:0] rnd_rdata, lim_rdata;
    logic [4:0]  sel_rdata;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    coef_loader u_dut (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .pause(pause), .ld_word(ld_word),
        .coef_we(coef_we), .coef_waddr(coef_waddr), .coef_wdata(coef_wdata),
        .cfg_we(cfg_we), .rnd_we(rnd_we), .sel_we(sel_we), .lim_we(lim_we),
        .reg_widx(reg_widx), .reg_wdata(reg_wdata),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_idx(rd_idx),
        .coef_rdata(coef_rdata), .cfg_rdata(cfg_rdata), .rnd_rdata(rnd_rdata),
        .sel_rdata(sel_rdata), .lim_rdata(lim_rdata)
    );

    task automatic check(input logic [15:0] tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_back(input logic [15:0] tag, input logic [2:0] kind,
                             input logic [3:0] idx, input logic [7:0] addr,
                             input logic [31:0] exp);
        logic [31:0] act;
        rd_idx  = idx;
        rd_bank = idx[1:0];
        rd_addr = addr;
        #1;
        case (kind)
            3'd0:    act = {20'd0, cfg_rdata};
            3'd1:    act = rnd_rdata;
            3'd2:    act = {27'd0, sel_rdata};
            3'd3:    act = lim_rdata;
            default: act = {20'd0, coef_rdata};
        endcase
        check(tag, act, exp);
    endtask

    task automatic word(input logic l, input logic p, input logic [11:0] w);
        @(negedge clk);
        ld_n = l;
        pause = p;
        ld_word = w;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        read_back("R1", 3'd1, 4'd7, 8'd0, 32'h0);
        read_back("R1", 3'd3, 4'd3, 8'd0, 32'h0);
        check("R1", {28'd0, coef_we}, 32'h0);

        // Table walk
        for (int i = 0; i < STIM_N; i++) word(STIM[i][13], STIM[i][12], STIM[i][11:0]);
        word(1'b1, 1'b0, 12'h000);
        for (int i = 0; i < CHK_N; i++)
            read_back(CHK[i].tag, CHK[i].kind, CHK[i].idx, CHK[i].addr, CHK[i].exp);

        // R4: wrap of the write location, bank 2
        word(1'b0, 1'b0, 12'h200);
        for (int i = 0; i < 258; i++) begin
            word(1'b0, 1'b0, 12'(i));
            if (i == 256) begin
                #1;
                // R10: exactly the bank 2 strobe, at wrapped location 0
                check("R10", {28'd0, coef_we}, 32'h4);
                check("R4", {24'd0, coef_waddr}, 32'h0);
            end
        end
        word(1'b1, 1'b0, 12'h000);
        read_back("R4", 3'd4, 4'd2, 8'd0, 32'h100);
        read_back("R4", 3'd4, 4'd2, 8'd1, 32'h101);
        read_back("R4", 3'd4, 4'd2, 8'd2, 32'h002);
        read_back("R4", 3'd4, 4'd2, 8'd255, 32'h0FF);

        // R1: reset clears registers written earlier
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_back("R1", 3'd1, 4'd7, 8'd0, 32'h0);
        read_back("R1", 3'd4, 4'd1, 8'd0, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule